// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked host and a byte-wide asynchronous static RAM with 128K locations. The host raises a request level with a write flag, a 17-bit address and a data byte. The controller then runs the memory's chip-select, write-strobe and output-gate lines through a fixed, clock-counted sequence. When the access is finished it pulses a done flag. For a read, the returned byte is presented at the same time as done.

Each analog timing limit of the memory is given in nanoseconds per speed grade. At elaboration the limit is turned into whole clock cycles by rounding up, with a floor of one cycle. A grade parameter and a clock-period parameter choose the values, so no count is entered by hand. The bidirectional data pins are modelled as three signals: data toward the memory, data from the memory, and a drive enable. Pad logic outside the block joins them.

Every access starts with one cycle in which the address is presented and all strobes are high. A write then holds chip-select and write-strobe low together, with the output gate high. It ends with a recovery gap. A read holds chip-select and output gate low, captures the data when the access count runs out, and then waits out the bus release time before reporting done.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is asserted, and until the first request after it, the strobes (mem_ce_n, mem_we_n, mem_oe_n) are 1. mem_dq_oe, host_done, mem_addr and host_rdata are 0.
- R2: A request is taken only when the controller is idle, host_req is 1 and host_done is 0. The write flag, address and data are latched at that edge. Changes on host inputs while an access is in progress have no effect on mem_addr, mem_dq_out or the access type.
- R3: Every access begins with exactly one cycle in which the new address is on mem_addr and all three strobes are 1. mem_addr changes only while mem_ce_n and mem_we_n are both 1, and were 1 in the previous cycle.
- R4: A write (host_wr=1) holds mem_ce_n=0 and mem_we_n=0 for WP cycles. WP is the larger of the rounded-up pulse width and the rounded-up data setup time: 6 cycles for grade 0 at a 10 ns clock. mem_oe_n stays 1 for the whole write.
- R5: During a write, mem_dq_oe is 1 from the first cycle with mem_we_n=0 through exactly one cycle after mem_we_n returns to 1, and is 0 at all other times. While it is 1, mem_dq_out carries the latched write byte.
- R6: After the write pulse, all strobes stay 1 for REC cycles before done. REC is the larger of the rounded-up recovery time and whatever remains of the write cycle time after the setup cycle and pulse: 1 cycle for grade 0 at 10 ns.
- R7: A read (host_wr=0) holds mem_ce_n=0 and mem_oe_n=0, with mem_we_n=1, for RD cycles. RD is the largest of the rounded-up address access time, the rounded-up output-gate access time, and the rounded-up read cycle time less one: 7 cycles for grade 0 at 10 ns. mem_dq_in is sampled into host_rdata on the clock edge that ends this window.
- R8: After a read, all strobes stay 1 for HZ cycles before done. HZ is the rounded-up worst bus release time: 3 cycles for grade 0 at 10 ns.
- R9: host_done is high for exactly one cycle, in the first idle cycle after an access. host_rdata holds its value until the next read captures.
- R10: Each interval is converted from nanoseconds to cycles as ceil(ns*1000/CLK_PS), with a minimum of 1. The grade parameter selects the nanosecond set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_req | input | 1 | Access request level |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 17 | Byte address |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Last byte read |
| host_done | output | 1 | One-cycle end-of-access pulse |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output gate, active low |
| mem_addr | output | 17 | Memory address bus |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Data returned by the memory |

## Verification
The hardest case to reach is a request that stays high across the done pulse. The controller must skip exactly that one cycle and then start the next access with the new address and type. The stimulus reaches it with chained transactions: the bench switches to the next operation in the same cycle that done appears and never drops the request. Host inputs are also scrambled in the middle of some accesses. A behavioural memory in the bench stores only what is written under the real strobes. Read-back of every location therefore shows whether the data window and the address freeze were right.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WREC   = 3'd3,
    ST_RACC   = 3'd4,
    ST_RTURN  = 3'd5
  } seq_state_e;

  // selectors for the nanosecond table
  localparam int T_RC  = 0;  // read / write cycle, address access
  localparam int T_OE  = 1;  // output gate access
  localparam int T_WP  = 2;  // write pulse width
  localparam int T_DS  = 3;  // data setup before end of write
  localparam int T_HZ  = 4;  // worst bus release after deselect
  localparam int T_REC = 5;  // write recovery

  function automatic int grade_ns(input int grade, input int kind);
    int v;
    v = 0;
    case (kind)
      T_RC:  case (grade) 1: v = 85; 2: v = 120; 3: v = 150; default: v = 70; endcase
      T_OE:  case (grade) 1: v = 45; 2: v = 60;  3: v = 70;  default: v = 35; endcase
      T_WP:  case (grade) 1: v = 65; 2: v = 85;  3: v = 90;  default: v = 55; endcase
      T_DS:  case (grade) 1: v = 35; 2: v = 45;  3: v = 50;  default: v = 30; endcase
      T_HZ:  case (grade) 1: v = 35; 2: v = 45;  3: v = 60;  default: v = 25; endcase
      default: v = 5;
    endcase
    return v;
  endfunction

  function automatic int ns_to_cyc(input int ns, input int clk_ps);
    int c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/sram_reset_sync.sv
module sram_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int RD_CYC  = 7,
  parameter int WP_CYC  = 6,
  parameter int REC_CYC = 1,
  parameter int HZ_CYC  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             wr_q,
  input  logic             expired,
  output logic             accept,
  output logic             capture,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             ce_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             dq_oe,
  output logic             done
);
  localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LOAD  = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LOAD = CNT_W'(REC_CYC - 1);
  localparam logic [CNT_W-1:0] HZ_LOAD  = CNT_W'(HZ_CYC - 1);

  seq_state_e state_q, state_d;
  logic ce_n_q, we_n_q, oe_n_q, dq_oe_q, done_q;
  logic ce_n_d, we_n_d, oe_n_d, dq_oe_d, done_d;

  // next-state and timer control
  always_comb begin
    state_d  = state_q;
    accept   = 1'b0;
    capture  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE: begin
        if (req && !done_q) begin
          state_d  = ST_SETUP;
          accept   = 1'b1;
          tmr_load = 1'b1;
        end
      end
      ST_SETUP: begin
        tmr_load = 1'b1;
        if (wr_q) begin
          state_d = ST_WPULSE;
          tmr_val = WP_LOAD;
        end else begin
          state_d = ST_RACC;
          tmr_val = RD_LOAD;
        end
      end
      ST_WPULSE: begin
        if (expired) begin
          state_d  = ST_WREC;
          tmr_load = 1'b1;
          tmr_val  = REC_LOAD;
        end
      end
      ST_WREC: begin
        if (expired) state_d = ST_IDLE;
      end
      ST_RACC: begin
        if (expired) begin
          state_d  = ST_RTURN;
          capture  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = HZ_LOAD;
        end
      end
      ST_RTURN: begin
        if (expired) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registered strobe values derived from the next state
  always_comb begin
    ce_n_d  = !((state_d == ST_WPULSE) || (state_d == ST_RACC));
    we_n_d  = (state_d != ST_WPULSE);
    oe_n_d  = (state_d != ST_RACC);
    dq_oe_d = (state_d == ST_WPULSE) ||
              ((state_q == ST_WPULSE) && (state_d == ST_WREC));
    done_d  = (state_d == ST_IDLE) && (state_q != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ce_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_n_q  <= ce_n_d;
      we_n_q  <= we_n_d;
      oe_n_q  <= oe_n_d;
      dq_oe_q <= dq_oe_d;
      done_q  <= done_d;
    end
  end

  assign ce_n  = ce_n_q;
  assign we_n  = we_n_q;
  assign oe_n  = oe_n_q;
  assign dq_oe = dq_oe_q;
  assign done  = done_q;
endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic [DW-1:0] mem_dq_in,
  output logic          wr_q,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic [DW-1:0] host_rdata
);
  logic          wr_r;
  logic [AW-1:0] addr_r;
  logic [DW-1:0] wdata_r, rdata_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_r    <= 1'b0;
      addr_r  <= '0;
      wdata_r <= '0;
    end else if (accept) begin
      wr_r    <= host_wr;
      addr_r  <= host_addr;
      wdata_r <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_r <= '0;
    else if (capture) rdata_r <= mem_dq_in;
  end

  assign wr_q       = wr_r;
  assign mem_addr   = addr_r;
  assign mem_dq_out = wdata_r;
  assign host_rdata = rdata_r;
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PS      = 10000,
  parameter int GRADE       = 0,
  parameter int AW          = 17,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_done,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int C_RC  = ns_to_cyc(grade_ns(GRADE, T_RC),  CLK_PS);
  localparam int C_OE  = ns_to_cyc(grade_ns(GRADE, T_OE),  CLK_PS);
  localparam int C_WP  = ns_to_cyc(grade_ns(GRADE, T_WP),  CLK_PS);
  localparam int C_DS  = ns_to_cyc(grade_ns(GRADE, T_DS),  CLK_PS);
  localparam int C_HZ  = ns_to_cyc(grade_ns(GRADE, T_HZ),  CLK_PS);
  localparam int C_REC = ns_to_cyc(grade_ns(GRADE, T_REC), CLK_PS);

  localparam int RD_CYC  = max3(C_RC, C_OE, C_RC - 1);
  localparam int WP_CYC  = max3(C_WP, C_DS, 1);
  localparam int REC_CYC = max3(C_REC, C_RC - 1 - WP_CYC, 1);
  localparam int HZ_CYC  = C_HZ;
  localparam int MAX_CYC = max3(max3(RD_CYC, WP_CYC, REC_CYC), HZ_CYC, 1);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             rst_int_n;
  logic             accept, capture, tmr_load, expired, wr_q;
  logic [CNT_W-1:0] tmr_val;

  sram_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  sram_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  sram_seq_fsm #(
    .CNT_W   (CNT_W),
    .RD_CYC  (RD_CYC),
    .WP_CYC  (WP_CYC),
    .REC_CYC (REC_CYC),
    .HZ_CYC  (HZ_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .req      (host_req),
    .wr_q     (wr_q),
    .expired  (expired),
    .accept   (accept),
    .capture  (capture),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .ce_n     (mem_ce_n),
    .we_n     (mem_we_n),
    .oe_n     (mem_oe_n),
    .dq_oe    (mem_dq_oe),
    .done     (host_done)
  );

  sram_data_path #(.AW(AW), .DW(DW)) u_dp (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .accept     (accept),
    .capture    (capture),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .mem_dq_in  (mem_dq_in),
    .wr_q       (wr_q),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .host_rdata (host_rdata)
  );
endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
  parameter int AW     = 17,
  parameter int WP_CYC = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          we_n,
  input logic          oe_n,
  input logic          dq_oe,
  input logic          done,
  input logic [AW-1:0] addr
);
  logic [15:0] low_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      low_run_q <= '0;
    else if (!we_n && low_run_q != 16'hFFFF) low_run_q <= low_run_q + 16'd1;
    else if (we_n)                   low_run_q <= '0;
  end

  // R4: output gate never open while the write strobe is low
  p_oe_shut_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (oe_n && !ce_n));

  // R4: the write strobe stays low for at least the counted pulse
  p_pulse_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (low_run_q >= 16'(WP_CYC)));

  // R3: address moves only with both select and write strobe idle
  p_addr_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr) |-> (ce_n && we_n && $past(ce_n) && $past(we_n)));

  // R5: controller drives data only in the write window plus one hold cycle
  p_drive_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!we_n || $past(!we_n)));

  // R7: a read gate is never opened together with a write strobe
  p_read_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (we_n && !ce_n));

  // R9: completion is a single-cycle pulse
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(.AW(AW), .WP_CYC(WP_CYC)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .ce_n  (mem_ce_n),
  .we_n  (mem_we_n),
  .oe_n  (mem_oe_n),
  .dq_oe (mem_dq_oe),
  .done  (host_done),
  .addr  (mem_addr)
);

// File: tb/tb_sram_cycle_ctrl.sv
module tb_sram_cycle_ctrl;
  localparam int CLK_PERIOD = 10;

  function automatic int cdiv(input int ns);
    int c;
    c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // grade 0 figures, converted independently of the design
  localparam int WP_B  = imax(cdiv(55), cdiv(30));
  localparam int RD_B  = imax(imax(cdiv(70), cdiv(35)), cdiv(70) - 1);
  localparam int HZ_B  = cdiv(25);
  localparam int REC_B = imax(imax(cdiv(5), cdiv(70) - 1 - WP_B), 1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_wr = 1'b0;
  logic [16:0] host_addr = '0;
  logic [7:0]  host_wdata = '0, mem_dq_in = '0;
  logic [7:0]  host_rdata, mem_dq_out;
  logic [16:0] mem_addr;
  logic        host_done, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;

  sram_cycle_ctrl dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_done(host_done), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [16:0] a;
    logic [7:0]  d;
    logic        chain;
    logic        noise;
  } txn_t;

  txn_t q[$];
  logic [7:0] bmem [logic [16:0]];   // memory behind the pins
  logic [7:0] rmem [logic [16:0]];   // reference contents

  int checks = 0, errors = 0;
  bit finished = 0;
  int since_rst = 0;

  // reference model state
  bit          m_busy = 0, m_wr = 0, e_done = 0;
  int          m_k = 0;
  logic [16:0] m_a = '0;
  logic [7:0]  m_d = '0, e_rdata = '0;
  int          we_run = 0, rd_run = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string phase_tag();
    if (!m_busy) return e_done ? "R9" : "R2";
    if (m_k == 0) return "R3";
    if (m_wr) return (m_k <= WP_B) ? "R4" : "R6";
    return (m_k <= RD_B) ? "R7" : "R8";
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      // R1: idle values under reset
      chk("R1", "ce_n", int'(mem_ce_n), 1);
      chk("R1", "we_n", int'(mem_we_n), 1);
      chk("R1", "oe_n", int'(mem_oe_n), 1);
      chk("R1", "dq_oe", int'(mem_dq_oe), 0);
      chk("R1", "done", int'(host_done), 0);
      chk("R1", "addr", int'(mem_addr), 0);
      chk("R1", "rdata", int'(host_rdata), 0);
    end else if (!finished) begin
      bit pd;
      bit ce_e, we_e, oe_e, dq_e;
      string tg;
      since_rst++;
      // advance the reference across the edge just passed
      pd = e_done;
      e_done = 0;
      if (!m_busy) begin
        if (host_req && !pd) begin
          m_busy = 1; m_k = 0;
          m_wr = host_wr; m_a = host_addr; m_d = host_wdata;
          if (m_wr) rmem[m_a] = m_d;
        end
      end else begin
        m_k++;
        if (!m_wr && m_k == RD_B + 1)
          e_rdata = rmem.exists(m_a) ? rmem[m_a] : 8'h00;
        if (m_k == (m_wr ? 1 + WP_B + REC_B : 1 + RD_B + HZ_B)) begin
          m_busy = 0;
          e_done = 1;
        end
      end
      // expected pins
      ce_e = !(m_busy && m_k >= 1 && m_k <= (m_wr ? WP_B : RD_B));
      we_e = !(m_busy && m_wr && m_k >= 1 && m_k <= WP_B);
      oe_e = !(m_busy && !m_wr && m_k >= 1 && m_k <= RD_B);
      dq_e = m_busy && m_wr && m_k >= 1 && m_k <= WP_B + 1;
      tg = phase_tag();
      chk(tg, "ce_n", int'(mem_ce_n), int'(ce_e));
      chk(tg, "we_n", int'(mem_we_n), int'(we_e));
      chk(tg, "oe_n", int'(mem_oe_n), int'(oe_e));
      chk("R5", "dq_oe", int'(mem_dq_oe), int'(dq_e));
      if (dq_e) chk("R5", "dq_out", int'(mem_dq_out), int'(m_d));
      chk("R2", "addr", int'(mem_addr), int'(m_a));
      chk("R9", "done", int'(host_done), int'(e_done));
      chk("R7", "rdata", int'(host_rdata), int'(e_rdata));
      // R10: measured strobe windows against bench-side cycle conversion
      if (!mem_we_n) we_run++;
      else if (we_run > 0) begin chk("R10", "write pulse cycles", we_run, WP_B); we_run = 0; end
      if (!mem_oe_n) rd_run++;
      else if (rd_run > 0) begin chk("R10", "read window cycles", rd_run, RD_B); rd_run = 0; end
      // memory behind the pins
      if (!mem_ce_n && !mem_we_n) bmem[mem_addr] = mem_dq_oe ? mem_dq_out : 8'h5A;
      if (!mem_ce_n && !mem_oe_n && mem_we_n)
        mem_dq_in = bmem.exists(mem_addr) ? bmem[mem_addr] : 8'h00;
      else
        mem_dq_in = 8'hE7;
      // host driver
      if (e_done) begin
        txn_t cur;
        cur = q.pop_front();
        if (cur.chain && q.size() > 0) begin
          host_req = 1; host_wr = q[0].wr; host_addr = q[0].a; host_wdata = q[0].d;
        end else host_req = 0;
      end else if (!host_req && !m_busy && q.size() > 0 && since_rst > 4) begin
        host_req = 1; host_wr = q[0].wr; host_addr = q[0].a; host_wdata = q[0].d;
      end else if (m_busy && m_k >= 1 && q.size() > 0 && q[0].noise) begin
        host_wr = ~q[0].wr; host_addr = ~q[0].a; host_wdata = ~q[0].d;
      end
      if (q.size() == 0 && !m_busy && !e_done && !host_req && since_rst > 4) begin
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  function automatic txn_t mk(input logic wr, input logic [16:0] a, input logic [7:0] d,
                              input logic chain, input logic noise);
    txn_t t;
    t.wr = wr; t.a = a; t.d = d; t.chain = chain; t.noise = noise;
    return t;
  endfunction

  initial begin
    q.push_back(mk(1, 17'h00000, 8'h3C, 0, 0));
    q.push_back(mk(1, 17'h1FFFF, 8'hC3, 0, 1));   // host inputs scrambled mid-access
    q.push_back(mk(1, 17'h0AAAA, 8'h55, 0, 0));
    q.push_back(mk(0, 17'h00000, 8'h00, 0, 0));
    q.push_back(mk(0, 17'h1FFFF, 8'h00, 0, 1));
    q.push_back(mk(0, 17'h0AAAA, 8'h00, 0, 0));
    q.push_back(mk(0, 17'h12345, 8'h00, 0, 0));   // never written
    q.push_back(mk(1, 17'h00010, 8'h7E, 1, 0));   // request held across done
    q.push_back(mk(0, 17'h00010, 8'h00, 1, 0));
    q.push_back(mk(1, 17'h00010, 8'h81, 1, 1));
    q.push_back(mk(0, 17'h00010, 8'h00, 1, 0));
    q.push_back(mk(1, 17'h15555, 8'hAA, 0, 0));
    q.push_back(mk(0, 17'h15555, 8'h00, 0, 1));
    #(CLK_PERIOD * 3 + 2);
    rst_n = 1'b1;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule